// File: doc/BRIEF.md
# Single-Wire Device Flag Controller

This block is the transaction front end of a device that sits on a single-wire bus. A bit-level decoder delivers one byte at a time. The first byte of every transaction is a flag. The flag puts the device to sleep, puts it in idle, opens a command write into the input buffer, or asks for the response held in the output buffer. The controller decodes that flag, steps the device between its power states, writes command bytes to consecutive buffer addresses, waits out a bus turnaround and then streams the response. It sends the response again each time the request is repeated.

While the device sleeps or idles, every byte is dropped and only a wake pulse brings it back. Sleep differs from idle in what survives. Sleep entry issues a volatile-clear strobe, and idle entry issues a retain strobe so that the key and seed registers hold their contents. While the command engine is busy, bytes are dropped.

Top module: `swflag_ctrl`

## Requirements
- R1: After reset the device is asleep (`sleep_st`=1, `idle_st`=0), with `tx_valid`, `cmd_wr_en`, `vol_clr`, `retain`, `wdt_clr` and `rsv_err` all low.
- R2: In sleep or idle every received byte is discarded. A `wake_pulse` makes the device awake, and `wdt_clr` is high for exactly the one cycle after the edge that sampled the wake. A wake received while already awake has no effect.
- R3: Flag 0xCC puts the device to sleep. `vol_clr` pulses for one cycle and `rsv_err` is cleared.
- R4: Flag 0xBB puts the device in idle, and `retain` pulses for one cycle.
- R5: After flag 0x77, each following byte is written one cycle after its sampling edge, at addresses 0, 1, 2 and onward. The byte at address 0 is a count N of the total bytes including itself. A count of 0 counts as 1, and a count above CMD_DEPTH counts as CMD_DEPTH. After N bytes the next byte is read as a flag.
- R6: Every new 0x77 flag restarts the write address at 0.
- R7: Flag 0x88 with a valid response starts a turnaround. `tx_valid` first rises TURN_CYC rising edges after the edge that sampled the flag. Response bytes at `ob_rd_addr` 0 through L-1 then appear on `tx_byte` in consecutive cycles, with `tx_start` high on the first byte only.
- R8: A repeated 0x88 sends the whole response again from address 0, for as long as the response stays valid.
- R9: `ob_load` marks the response valid and sets its length L to `ob_load_len`, clipped to the range 1 to RSP_DEPTH. Sleep, idle or any accepted command byte makes it invalid, and this clear wins over a load in the same cycle. A 0x88 received with no valid response has no effect.
- R10: While `cmd_busy` is high, received bytes are discarded, both flags and command bytes.
- R11: Any flag other than 0xCC, 0xBB, 0x77 or 0x88 sets the sticky `rsv_err` and leaves the state unchanged.
- R12: Bytes received during the turnaround or the transmission are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | A decoded byte is present |
| rx_byte | input | 8 | Decoded byte |
| wake_pulse | input | 1 | Legal wake token detected |
| cmd_busy | input | 1 | Command engine is executing |
| ob_load | input | 1 | Response written into output buffer |
| ob_load_len | input | $clog2(RSP_DEPTH+1) | Response length in bytes |
| ob_rd_data | input | 8 | Output buffer read data (combinational) |
| cmd_wr_en | output | 1 | Command buffer write strobe |
| cmd_wr_addr | output | $clog2(CMD_DEPTH) | Command buffer write address |
| cmd_wr_data | output | 8 | Command buffer write data |
| ob_rd_addr | output | $clog2(RSP_DEPTH) | Output buffer read address |
| tx_valid | output | 1 | Response byte present on tx_byte |
| tx_start | output | 1 | First byte of a response |
| tx_byte | output | 8 | Response byte |
| sleep_st | output | 1 | Device is asleep |
| idle_st | output | 1 | Device is idle |
| vol_clr | output | 1 | One-cycle strobe that clears volatile state |
| retain | output | 1 | One-cycle strobe to keep key and seed registers |
| wdt_clr | output | 1 | One-cycle watchdog reset strobe |
| rsv_err | output | 1 | Sticky reserved-flag error |

## Verification
A response load from the command engine can land in the same cycle as an event that invalidates the response. The bench provokes this by driving `ob_load` together with the count byte of a new command. It judges the outcome by a following 0x88, which must produce no transmission at all. The clear-only and load-only cases are also run, and their 0x88 results are compared with this one. Busy and byte arrival also coincide in a scenario: a byte held on the bus while `cmd_busy` is high must leave no write and no state change, and the next byte, sent after busy drops, must still be taken as the count at address 0.

// File: rtl/swflag_pkg.sv
package swflag_pkg;

  typedef enum logic [2:0] {
    ST_SLEEP,
    ST_IDLE,
    ST_FLAG,
    ST_CMDW,
    ST_XMIT
  } dev_state_e;

  typedef enum logic [2:0] {
    FL_SLEEP,
    FL_IDLE,
    FL_CMD,
    FL_XMIT,
    FL_RSV
  } flag_kind_e;

  localparam logic [7:0] FLAG_SLEEP = 8'hCC;
  localparam logic [7:0] FLAG_IDLE  = 8'hBB;
  localparam logic [7:0] FLAG_CMD   = 8'h77;
  localparam logic [7:0] FLAG_XMIT  = 8'h88;

  function automatic flag_kind_e classify(input logic [7:0] b);
    case (b)
      FLAG_SLEEP: return FL_SLEEP;
      FLAG_IDLE:  return FL_IDLE;
      FLAG_CMD:   return FL_CMD;
      FLAG_XMIT:  return FL_XMIT;
      default:    return FL_RSV;
    endcase
  endfunction

  // Length limit: zero counts as one, anything beyond the depth saturates.
  function automatic int clip_count(input int n, input int depth);
    if (n <= 0) return 1;
    if (n > depth) return depth;
    return n;
  endfunction

endpackage

// File: rtl/swflag_wr_cnt.sv
module swflag_wr_cnt
  import swflag_pkg::*;
#(
  parameter int CMD_DEPTH = 16,
  localparam int CAW = $clog2(CMD_DEPTH),
  localparam int CW  = $clog2(CMD_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           acc,
  input  logic [7:0]     acc_byte,
  output logic           wr_en,
  output logic [CAW-1:0] wr_addr,
  output logic [7:0]     wr_data,
  output logic           last
);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;
  logic [CW-1:0] n_eff;

  always_comb begin
    n_eff = (cnt == '0) ? CW'(clip_count(int'(acc_byte), CMD_DEPTH)) : limit;
    last  = acc && ((cnt + 1'b1) == n_eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      limit   <= CW'(1);
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= acc;
      if (start) begin
        cnt <= '0;
      end else if (acc) begin
        cnt     <= cnt + 1'b1;
        wr_addr <= cnt[CAW-1:0];
        wr_data <= acc_byte;
        if (cnt == '0) limit <= n_eff;
      end
    end
  end

endmodule

// File: rtl/swflag_obuf_state.sv
module swflag_obuf_state
  import swflag_pkg::*;
#(
  parameter int RSP_DEPTH = 16,
  localparam int LW = $clog2(RSP_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [LW-1:0] load_len,
  input  logic          clr,
  output logic          valid,
  output logic [LW-1:0] len
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      len   <= LW'(1);
    end else if (clr) begin
      valid <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      len   <= LW'(clip_count(int'(load_len), RSP_DEPTH));
    end
  end

endmodule

// File: rtl/swflag_tx_seq.sv
module swflag_tx_seq #(
  parameter int RSP_DEPTH = 16,
  parameter int TURN_CYC  = 4,
  localparam int RAW = $clog2(RSP_DEPTH),
  localparam int LW  = $clog2(RSP_DEPTH + 1),
  localparam int TW  = (TURN_CYC > 1) ? $clog2(TURN_CYC) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic [LW-1:0]  len_in,
  output logic           busy,
  output logic           tx_valid,
  output logic           tx_start,
  output logic [RAW-1:0] rd_addr,
  output logic           last
);

  typedef enum logic [1:0] {TS_OFF, TS_TURN, TS_SEND} phase_e;

  phase_e        phase;
  logic [TW-1:0] tcnt;
  logic [LW-1:0] len;
  logic          turn_done;

  assign turn_done = (phase == TS_TURN) && (tcnt == TW'(TURN_CYC - 1));
  assign busy      = (phase != TS_OFF);
  assign tx_valid  = (phase == TS_SEND);
  assign tx_start  = tx_valid && (rd_addr == '0);
  assign last      = tx_valid && ((LW'(rd_addr) + 1'b1) == len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= TS_OFF;
      tcnt    <= '0;
      len     <= LW'(1);
      rd_addr <= '0;
    end else begin
      case (phase)
        TS_OFF: if (go) begin
          phase   <= TS_TURN;
          tcnt    <= '0;
          len     <= len_in;
          rd_addr <= '0;
        end
        TS_TURN: begin
          if (turn_done) phase <= TS_SEND;
          else           tcnt  <= tcnt + 1'b1;
        end
        TS_SEND: begin
          if (last) phase   <= TS_OFF;
          else      rd_addr <= rd_addr + 1'b1;
        end
        default: phase <= TS_OFF;
      endcase
    end
  end

endmodule

// File: rtl/swflag_ctrl.sv
module swflag_ctrl
  import swflag_pkg::*;
#(
  parameter int CMD_DEPTH = 16,
  parameter int RSP_DEPTH = 16,
  parameter int TURN_CYC  = 4,
  localparam int CAW = $clog2(CMD_DEPTH),
  localparam int RAW = $clog2(RSP_DEPTH),
  localparam int LW  = $clog2(RSP_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rx_valid,
  input  logic [7:0]     rx_byte,
  input  logic           wake_pulse,
  input  logic           cmd_busy,
  input  logic           ob_load,
  input  logic [LW-1:0]  ob_load_len,
  input  logic [7:0]     ob_rd_data,
  output logic           cmd_wr_en,
  output logic [CAW-1:0] cmd_wr_addr,
  output logic [7:0]     cmd_wr_data,
  output logic [RAW-1:0] ob_rd_addr,
  output logic           tx_valid,
  output logic           tx_start,
  output logic [7:0]     tx_byte,
  output logic           sleep_st,
  output logic           idle_st,
  output logic           vol_clr,
  output logic           retain,
  output logic           wdt_clr,
  output logic           rsv_err
);

  dev_state_e st;
  flag_kind_e fl;

  // Named events, shared by the state machine and the bound checker.
  logic rx_take;
  logic ev_wake, ev_flag, ev_go_sleep, ev_go_idle, ev_cmd_start;
  logic ev_xmit, ev_rsv, ev_cmd_byte, ev_cmd_last, ev_xmit_end;
  logic ob_clr, ob_valid;
  logic [LW-1:0] ob_len;
  logic seq_busy;

  assign fl           = classify(rx_byte);
  assign rx_take      = rx_valid && !cmd_busy;
  assign ev_wake      = wake_pulse && ((st == ST_SLEEP) || (st == ST_IDLE));
  assign ev_flag      = rx_take && (st == ST_FLAG);
  assign ev_go_sleep  = ev_flag && (fl == FL_SLEEP);
  assign ev_go_idle   = ev_flag && (fl == FL_IDLE);
  assign ev_cmd_start = ev_flag && (fl == FL_CMD);
  assign ev_xmit      = ev_flag && (fl == FL_XMIT) && ob_valid;
  assign ev_rsv       = ev_flag && (fl == FL_RSV);
  assign ev_cmd_byte  = rx_take && (st == ST_CMDW);
  assign ob_clr       = ev_go_sleep || ev_go_idle || ev_cmd_byte;

  swflag_wr_cnt #(.CMD_DEPTH(CMD_DEPTH)) u_wr (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (ev_cmd_start),
    .acc      (ev_cmd_byte),
    .acc_byte (rx_byte),
    .wr_en    (cmd_wr_en),
    .wr_addr  (cmd_wr_addr),
    .wr_data  (cmd_wr_data),
    .last     (ev_cmd_last)
  );

  swflag_obuf_state #(.RSP_DEPTH(RSP_DEPTH)) u_ob (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ob_load),
    .load_len (ob_load_len),
    .clr      (ob_clr),
    .valid    (ob_valid),
    .len      (ob_len)
  );

  swflag_tx_seq #(.RSP_DEPTH(RSP_DEPTH), .TURN_CYC(TURN_CYC)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (ev_xmit),
    .len_in   (ob_len),
    .busy     (seq_busy),
    .tx_valid (tx_valid),
    .tx_start (tx_start),
    .rd_addr  (ob_rd_addr),
    .last     (ev_xmit_end)
  );

  assign tx_byte  = tx_valid ? ob_rd_data : 8'h00;
  assign sleep_st = (st == ST_SLEEP);
  assign idle_st  = (st == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_SLEEP;
      vol_clr <= 1'b0;
      retain  <= 1'b0;
      wdt_clr <= 1'b0;
      rsv_err <= 1'b0;
    end else begin
      vol_clr <= ev_go_sleep;
      retain  <= ev_go_idle;
      wdt_clr <= ev_wake;
      if (ev_go_sleep)  rsv_err <= 1'b0;
      else if (ev_rsv)  rsv_err <= 1'b1;
      case (st)
        ST_SLEEP, ST_IDLE: if (ev_wake) st <= ST_FLAG;
        ST_FLAG: begin
          if (ev_go_sleep)       st <= ST_SLEEP;
          else if (ev_go_idle)   st <= ST_IDLE;
          else if (ev_cmd_start) st <= ST_CMDW;
          else if (ev_xmit)      st <= ST_XMIT;
        end
        ST_CMDW: if (ev_cmd_last) st <= ST_FLAG;
        ST_XMIT: if (ev_xmit_end || !seq_busy) st <= ST_FLAG;
        default: st <= ST_SLEEP;
      endcase
    end
  end

endmodule

// File: rtl/swflag_ctrl_chk.sv
module swflag_ctrl_chk #(
  parameter int CAW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wake_pulse,
  input logic           cmd_busy,
  input logic           cmd_wr_en,
  input logic [CAW-1:0] cmd_wr_addr,
  input logic           tx_valid,
  input logic           tx_start,
  input logic           sleep_st,
  input logic           idle_st,
  input logic           vol_clr,
  input logic           retain,
  input logic           wdt_clr,
  input logic           rsv_err,
  input logic           ev_rsv
);

  assert_modes_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sleep_st, idle_st, tx_valid}));

  assert_asleep_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_st && !wake_pulse |=> sleep_st && !cmd_wr_en);

  assert_wake_clears_wdt_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_st || idle_st) && wake_pulse |=> wdt_clr && !sleep_st && !idle_st);

  assert_vol_clr_sleep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    vol_clr |-> sleep_st);

  assert_err_clear_on_sleep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rsv_err) |-> vol_clr);

  assert_retain_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    retain |-> idle_st);

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr_en && $past(cmd_wr_en) |-> cmd_wr_addr == $past(cmd_wr_addr) + 1'b1);

  assert_stream_contig_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_start |-> $past(tx_valid));

  assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_busy |=> !cmd_wr_en);

  assert_rsv_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rsv |=> rsv_err && !sleep_st && !idle_st);

endmodule

bind swflag_ctrl swflag_ctrl_chk #(.CAW(CAW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wake_pulse  (wake_pulse),
  .cmd_busy    (cmd_busy),
  .cmd_wr_en   (cmd_wr_en),
  .cmd_wr_addr (cmd_wr_addr),
  .tx_valid    (tx_valid),
  .tx_start    (tx_start),
  .sleep_st    (sleep_st),
  .idle_st     (idle_st),
  .vol_clr     (vol_clr),
  .retain      (retain),
  .wdt_clr     (wdt_clr),
  .rsv_err     (rsv_err),
  .ev_rsv      (ev_rsv)
);

// File: tb/swflag_ctrl_test.sv
`timescale 1ns/1ps
module swflag_ctrl_test;
  localparam int CMD_DEPTH = 16;
  localparam int RSP_DEPTH = 16;
  localparam int TURN_CYC  = 4;
  localparam int CAW = $clog2(CMD_DEPTH);
  localparam int RAW = $clog2(RSP_DEPTH);
  localparam int LW  = $clog2(RSP_DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic wake_pulse = 1'b0;
  logic cmd_busy = 1'b0;
  logic ob_load = 1'b0;
  logic [LW-1:0] ob_load_len = '0;
  logic [7:0] ob_rd_data;
  logic cmd_wr_en;
  logic [CAW-1:0] cmd_wr_addr;
  logic [7:0] cmd_wr_data;
  logic [RAW-1:0] ob_rd_addr;
  logic tx_valid, tx_start;
  logic [7:0] tx_byte;
  logic sleep_st, idle_st, vol_clr, retain, wdt_clr, rsv_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] rsp_val(input int i);
    return 8'(8'h40 + 3 * i);
  endfunction

  assign ob_rd_data = rsp_val(int'(ob_rd_addr));

  swflag_ctrl #(.CMD_DEPTH(CMD_DEPTH), .RSP_DEPTH(RSP_DEPTH), .TURN_CYC(TURN_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .wake_pulse(wake_pulse), .cmd_busy(cmd_busy), .ob_load(ob_load),
    .ob_load_len(ob_load_len), .ob_rd_data(ob_rd_data), .cmd_wr_en(cmd_wr_en),
    .cmd_wr_addr(cmd_wr_addr), .cmd_wr_data(cmd_wr_data), .ob_rd_addr(ob_rd_addr),
    .tx_valid(tx_valid), .tx_start(tx_start), .tx_byte(tx_byte),
    .sleep_st(sleep_st), .idle_st(idle_st), .vol_clr(vol_clr), .retain(retain),
    .wdt_clr(wdt_clr), .rsv_err(rsv_err)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic send_with_load(input logic [7:0] b, input int len);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b; ob_load = 1'b1; ob_load_len = LW'(len);
    @(negedge clk); rx_valid = 1'b0; ob_load = 1'b0;
  endtask

  task automatic wake();
    @(negedge clk); wake_pulse = 1'b1;
    @(negedge clk); wake_pulse = 1'b0;
  endtask

  task automatic load_rsp(input int len);
    @(negedge clk); ob_load = 1'b1; ob_load_len = LW'(len);
    @(negedge clk); ob_load = 1'b0;
  endtask

  // Called right after send(0x88): the current negedge follows the sampling edge.
  task automatic expect_tx(input string req, input int n, input bit inject);
    chk(req, "tx_valid during turnaround", 32'(tx_valid), 32'd0);
    if (inject) begin rx_valid = 1'b1; rx_byte = 8'hCC; end
    for (int k = 1; k < TURN_CYC; k++) begin
      @(negedge clk); rx_valid = 1'b0;
      chk(req, "tx_valid during turnaround", 32'(tx_valid), 32'd0);
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rx_valid = 1'b0;
      chk(req, "tx_valid", 32'(tx_valid), 32'd1);
      chk(req, "tx_start", 32'(tx_start), 32'(i == 0));
      chk(req, "ob_rd_addr", 32'(ob_rd_addr), 32'(i));
      chk(req, "tx_byte", 32'(tx_byte), 32'(rsp_val(i)));
    end
    @(negedge clk);
    chk(req, "tx_valid after stream", 32'(tx_valid), 32'd0);
    chk("R12", "sleep_st after stream", 32'(sleep_st), 32'd0);
  endtask

  task automatic expect_no_tx(input string req);
    bit seen = 1'b0;
    for (int k = 0; k < TURN_CYC + 3; k++) begin
      @(negedge clk);
      if (tx_valid) seen = 1'b1;
    end
    chk(req, "no transmission", 32'(seen), 32'd0);
  endtask

  task automatic cmd_write(input string req, input logic [7:0] cnt, input int n);
    send(8'h77);
    chk(req, "no write on flag", 32'(cmd_wr_en), 32'd0);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = (i == 0) ? cnt : 8'(8'hA0 + i);
      send(b);
      chk(req, "cmd_wr_en", 32'(cmd_wr_en), 32'd1);
      chk(req, "cmd_wr_addr", 32'(cmd_wr_addr), 32'(i));
      chk(req, "cmd_wr_data", 32'(cmd_wr_data), 32'(b));
    end
  endtask

  task automatic t_reset();
    chk("R1", "sleep_st", 32'(sleep_st), 32'd1);
    chk("R1", "idle_st", 32'(idle_st), 32'd0);
    chk("R1", "tx_valid", 32'(tx_valid), 32'd0);
    chk("R1", "cmd_wr_en", 32'(cmd_wr_en), 32'd0);
    chk("R1", "strobes", 32'({vol_clr, retain, wdt_clr}), 32'd0);
    chk("R1", "rsv_err", 32'(rsv_err), 32'd0);
  endtask

  task automatic t_sleep_wake();
    send(8'h77);
    send(8'h03);
    chk("R2", "write while asleep", 32'(cmd_wr_en), 32'd0);
    chk("R2", "sleep_st kept", 32'(sleep_st), 32'd1);
    wake();
    chk("R2", "sleep_st after wake", 32'(sleep_st), 32'd0);
    chk("R2", "wdt_clr pulse", 32'(wdt_clr), 32'd1);
    @(negedge clk);
    chk("R2", "wdt_clr one cycle", 32'(wdt_clr), 32'd0);
    wake();
    chk("R2", "wake while awake", 32'(wdt_clr), 32'd0);
  endtask

  task automatic t_idle_and_empty_xmit();
    send(8'h88);
    expect_no_tx("R9");
    send(8'hBB);
    chk("R4", "idle_st", 32'(idle_st), 32'd1);
    chk("R4", "retain pulse", 32'(retain), 32'd1);
    chk("R4", "no vol_clr", 32'(vol_clr), 32'd0);
    @(negedge clk);
    chk("R4", "retain one cycle", 32'(retain), 32'd0);
    send(8'h77);
    send(8'h02);
    chk("R2", "write while idle", 32'(cmd_wr_en), 32'd0);
    wake();
    chk("R2", "wake from idle", 32'(idle_st), 32'd0);
  endtask

  task automatic t_transmit();
    load_rsp(3);
    send(8'h88);
    expect_tx("R7", 3, 1'b1);
    send(8'h88);
    expect_tx("R8", 3, 1'b0);
    load_rsp(0);
    send(8'h88);
    expect_tx("R9", 1, 1'b0);
    load_rsp(20);
    send(8'h88);
    expect_tx("R9", RSP_DEPTH, 1'b0);
  endtask

  task automatic t_commands();
    cmd_write("R5", 8'h04, 4);
    send(8'h88);
    expect_no_tx("R9");
    cmd_write("R6", 8'h02, 2);
    cmd_write("R5", 8'h00, 1);
    send(8'hBB);
    chk("R5", "zero count ends after one byte", 32'(idle_st), 32'd1);
    wake();
    cmd_write("R5", 8'h40, CMD_DEPTH);
    send(8'hBB);
    chk("R5", "count clipped to depth", 32'(idle_st), 32'd1);
    wake();
  endtask

  task automatic t_overlap();
    send(8'h77);
    send_with_load(8'h01, 2);
    chk("R9", "count byte written", 32'(cmd_wr_en), 32'd1);
    send(8'h88);
    expect_no_tx("R9");
    load_rsp(2);
    send(8'h88);
    expect_tx("R9", 2, 1'b0);
  endtask

  task automatic t_busy();
    cmd_busy = 1'b1;
    send(8'hCC);
    chk("R10", "sleep ignored when busy", 32'(sleep_st), 32'd0);
    chk("R10", "no vol_clr when busy", 32'(vol_clr), 32'd0);
    send(8'h77);
    send(8'h01);
    chk("R10", "no write when busy", 32'(cmd_wr_en), 32'd0);
    cmd_busy = 1'b0;
    send(8'h77);
    cmd_busy = 1'b1;
    send(8'h05);
    chk("R10", "command byte dropped", 32'(cmd_wr_en), 32'd0);
    cmd_busy = 1'b0;
    send(8'h01);
    chk("R10", "next byte is count", 32'(cmd_wr_en), 32'd1);
    chk("R10", "count at address 0", 32'(cmd_wr_addr), 32'd0);
    chk("R10", "count data", 32'(cmd_wr_data), 32'h01);
  endtask

  task automatic t_reserved();
    send(8'h5A);
    chk("R11", "rsv_err set", 32'(rsv_err), 32'd1);
    chk("R11", "state kept", 32'({sleep_st, idle_st}), 32'd0);
    send(8'h13);
    chk("R11", "rsv_err sticky", 32'(rsv_err), 32'd1);
    cmd_write("R11", 8'h01, 1);
    send(8'hCC);
    chk("R3", "sleep_st", 32'(sleep_st), 32'd1);
    chk("R3", "vol_clr pulse", 32'(vol_clr), 32'd1);
    chk("R3", "rsv_err cleared", 32'(rsv_err), 32'd0);
    @(negedge clk);
    chk("R3", "vol_clr one cycle", 32'(vol_clr), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sleep_wake();
    t_idle_and_empty_xmit();
    t_transmit();
    t_commands();
    t_overlap();
    t_busy();
    t_reserved();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule